// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block sits beside the command arbiter of a DDR SDRAM controller. It counts clock cycles into refresh intervals. Each interval that ends adds one owed auto-refresh to a backlog, and the block raises a refresh request while anything is owed. When the arbiter grants the request, the block issues the REFRESH command code in that same cycle and the backlog drops by one. Up to eight refreshes may be deferred. At that limit the request is flagged urgent, and the backlog saturates rather than growing. The device generates the refresh row internally, so the block produces no address.

The block also runs the self-refresh sequence. An entry request first drains the backlog to zero. The block then issues one REFRESH with CKE driven low, which places the device in self refresh. In that state all other activity is suppressed and no backlog builds up. After an exit request, CKE stays low until the clock generator reports a stable clock for a set run of consecutive cycles. CKE then rises, and a hold-off output blocks every other command while NOPs are sent for the DLL relock window, 200 cycles by default. Normal interval counting then starts again from zero.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, refReq and refUrgent are 0, cke is 1, cmdCode is NOP (code 0) and holdOff is 0.
- R2: Each CLKS_PER_INTERVAL clocks of normal operation add one owed refresh. refReq is 1 exactly while the owed count is nonzero.
- R3: A cycle with grant=1 and refReq=1 drives cmdCode to REFRESH (code 1) in that same cycle and removes one owed refresh. A grant while refReq=0 leaves cmdCode at NOP and changes nothing.
- R4: refUrgent is 1 exactly when eight refreshes are owed. It is never 1 without refReq.
- R5: The owed count never exceeds eight. Further intervals at the limit are dropped, so eight grants clear it.
- R6: After an entry request (srEnterReq), refresh requests continue until the owed count is zero. The block then issues one cycle of cmdCode=REFRESH with cke=0, followed by cke=0 with cmdCode=NOP.
- R7: In self refresh, cke stays 0, cmdCode stays NOP, refReq stays 0 and holdOff is 1. grant and srEnterReq have no effect.
- R8: After an exit request (srExitReq), cke stays 0 until clkStable has been 1 for STABLE_CYCLES consecutive cycles. A low cycle on clkStable restarts the count. cke rises on the cycle after the last stable cycle.
- R9: From the cycle cke rises, holdOff is 1 for exactly NOP_CYCLES cycles. During that window cmdCode is NOP and refReq is 0, even with grant=1.
- R10: When holdOff falls, the owed count is zero and interval timing restarts. refReq first rises CLKS_PER_INTERVAL cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Arbiter grants the refresh request this cycle |
| srEnterReq | input | 1 | Request to enter self refresh |
| srExitReq | input | 1 | Request to leave self refresh |
| clkStable | input | 1 | Clock generator reports a stable clock |
| refReq | output | 1 | At least one refresh is owed |
| refUrgent | output | 1 | Owed count is at its limit of eight |
| cke | output | 1 | Clock-enable level for the device |
| cmdCode | output | 2 | Command from this block: 0 NOP, 1 REFRESH |
| holdOff | output | 1 | Other commands must not be issued |

## Verification
The bench lets the backlog run far past eight intervals. A design with no saturation would then need more than eight grants to clear it, and a design with the wrong urgency threshold would flag too early or too late. Grants are timed so that no interval boundary falls inside a grant burst, which keeps the expected count exact. On exit, the bench breaks the clkStable run part way through. A design that does not restart the stable count would raise CKE early. The hold-off window is measured to the cycle while grant is held high, which catches an off-by-one window or a REFRESH that leaks through. The first request after exit is timed to show that the backlog and the interval phase were both cleared.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_REFRESH = 2'd1
  } cmdCodeT;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_DRAIN,
    ST_SR_ENTER,
    ST_SELF,
    ST_EXIT_WAIT,
    ST_EXIT_NOP
  } schedStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic runInterval;   // interval timer and backlog active
    logic grantRefresh;  // a refresh is issued this cycle
    logic countWait;     // advance the wait counter, else clear it
  } rfshStrobeT;

endpackage

// File: rtl/rfsh_datapath.sv
`timescale 1ns/1ps
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int CLKS_PER_INTERVAL = 1560,
  parameter int MAX_POSTPONE      = 8,
  parameter int WAIT_W            = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfshStrobeT        strb,
  output logic              creditZero,
  output logic              creditFull,
  output logic [WAIT_W-1:0] waitCount
);

  localparam int INT_W    = (CLKS_PER_INTERVAL > 2) ? $clog2(CLKS_PER_INTERVAL) : 1;
  localparam int CREDIT_W = $clog2(MAX_POSTPONE + 1);
  localparam logic [INT_W-1:0]    INT_LAST   = INT_W'(CLKS_PER_INTERVAL - 1);
  localparam logic [CREDIT_W-1:0] CREDIT_MAX = CREDIT_W'(MAX_POSTPONE);

  logic [INT_W-1:0]    intervalCnt;
  logic [CREDIT_W-1:0] credit;
  logic                tick;

  assign tick = strb.runInterval && (intervalCnt == INT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !strb.runInterval) begin
      intervalCnt <= '0;
    end else if (tick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + INT_W'(1);
    end
  end

  // owed-refresh count, saturating at the postpone limit
  always_ff @(posedge clk) begin
    if (!rstN || !strb.runInterval) begin
      credit <= '0;
    end else if (tick && !strb.grantRefresh) begin
      if (credit != CREDIT_MAX) credit <= credit + CREDIT_W'(1);
    end else if (!tick && strb.grantRefresh) begin
      credit <= credit - CREDIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.countWait) begin
      waitCount <= '0;
    end else begin
      waitCount <= waitCount + WAIT_W'(1);
    end
  end

  assign creditZero = (credit == '0);
  assign creditFull = (credit == CREDIT_MAX);

endmodule

// File: rtl/rfsh_control.sv
`timescale 1ns/1ps
module rfsh_control
  import rfsh_pkg::*;
#(
  parameter int STABLE_CYCLES = 4,
  parameter int NOP_CYCLES    = 200,
  parameter int WAIT_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grant,
  input  logic              srEnterReq,
  input  logic              srExitReq,
  input  logic              clkStable,
  input  logic              creditZero,
  input  logic              creditFull,
  input  logic [WAIT_W-1:0] waitCount,
  output rfshStrobeT        strb,
  output logic              refReq,
  output logic              refUrgent,
  output logic              cke,
  output logic [1:0]        cmdCode,
  output logic              holdOff
);

  localparam logic [WAIT_W-1:0] STABLE_LAST = WAIT_W'(STABLE_CYCLES - 1);
  localparam logic [WAIT_W-1:0] NOP_LAST    = WAIT_W'(NOP_CYCLES - 1);

  schedStateT state, stateNext;
  logic       running;
  logic       stableDone;

  assign running    = (state == ST_NORMAL) || (state == ST_DRAIN);
  assign stableDone = clkStable && (waitCount == STABLE_LAST);

  always_comb begin
    stateNext = state;
    case (state)
      ST_NORMAL:    if (srEnterReq) stateNext = ST_DRAIN;
      ST_DRAIN:     if (creditZero) stateNext = ST_SR_ENTER;
      ST_SR_ENTER:  stateNext = ST_SELF;
      ST_SELF:      if (srExitReq) stateNext = ST_EXIT_WAIT;
      ST_EXIT_WAIT: if (stableDone) stateNext = ST_EXIT_NOP;
      ST_EXIT_NOP:  if (waitCount == NOP_LAST) stateNext = ST_NORMAL;
      default:      stateNext = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= stateNext;
  end

  assign refReq    = running && !creditZero;
  assign refUrgent = refReq && creditFull;

  always_comb begin
    strb.runInterval  = running;
    strb.grantRefresh = grant && refReq;
    strb.countWait    = ((state == ST_EXIT_WAIT) && clkStable && !stableDone)
                        || (state == ST_EXIT_NOP);
  end

  assign cke     = !((state == ST_SR_ENTER) || (state == ST_SELF) || (state == ST_EXIT_WAIT));
  assign holdOff = !running;
  assign cmdCode = ((state == ST_SR_ENTER) || strb.grantRefresh) ? CMD_REFRESH : CMD_NOP;

endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int CLKS_PER_INTERVAL = 1560,
  parameter int MAX_POSTPONE      = 8,
  parameter int STABLE_CYCLES     = 4,
  parameter int NOP_CYCLES        = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       grant,
  input  logic       srEnterReq,
  input  logic       srExitReq,
  input  logic       clkStable,
  output logic       refReq,
  output logic       refUrgent,
  output logic       cke,
  output logic [1:0] cmdCode,
  output logic       holdOff
);

  localparam int WAIT_MAX = (NOP_CYCLES > STABLE_CYCLES) ? NOP_CYCLES : STABLE_CYCLES;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  rfshStrobeT        strb;
  logic              creditZero;
  logic              creditFull;
  logic [WAIT_W-1:0] waitCount;

  rfsh_control #(
    .STABLE_CYCLES(STABLE_CYCLES),
    .NOP_CYCLES   (NOP_CYCLES),
    .WAIT_W       (WAIT_W)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .grant     (grant),
    .srEnterReq(srEnterReq),
    .srExitReq (srExitReq),
    .clkStable (clkStable),
    .creditZero(creditZero),
    .creditFull(creditFull),
    .waitCount (waitCount),
    .strb      (strb),
    .refReq    (refReq),
    .refUrgent (refUrgent),
    .cke       (cke),
    .cmdCode   (cmdCode),
    .holdOff   (holdOff)
  );

  rfsh_datapath #(
    .CLKS_PER_INTERVAL(CLKS_PER_INTERVAL),
    .MAX_POSTPONE     (MAX_POSTPONE),
    .WAIT_W           (WAIT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .creditZero(creditZero),
    .creditFull(creditFull),
    .waitCount (waitCount)
  );

endmodule

// File: rtl/rfsh_checker.sv
`timescale 1ns/1ps
module rfsh_checker
  import rfsh_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       grant,
  input logic       clkStable,
  input logic       refReq,
  input logic       refUrgent,
  input logic       cke,
  input logic [1:0] cmdCode,
  input logic       holdOff
);

  assert_urgent_has_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

  assert_refresh_granted_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_REFRESH && cke) |-> grant);

  assert_entry_then_self_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_REFRESH && !cke) |=> (!cke && cmdCode == CMD_NOP));

  assert_quiet_in_sr_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (!refReq && holdOff));

  assert_stable_before_cke_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (clkStable && $past(clkStable)));

  assert_hold_after_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> holdOff);

  assert_nop_during_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (holdOff && cke) |-> (cmdCode == CMD_NOP && !refReq));

endmodule

bind dram_refresh_sched rfsh_checker u_rfsh_checker (
  .clk      (clk),
  .rstN     (rstN),
  .grant    (grant),
  .clkStable(clkStable),
  .refReq   (refReq),
  .refUrgent(refUrgent),
  .cke      (cke),
  .cmdCode  (cmdCode),
  .holdOff  (holdOff)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

  localparam int INTERVAL = 16;
  localparam int STABLE   = 4;
  localparam int NOPS     = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       grant = 1'b0;
  logic       srEnterReq = 1'b0;
  logic       srExitReq = 1'b0;
  logic       clkStable = 1'b0;
  logic       refReq, refUrgent, cke, holdOff;
  logic [1:0] cmdCode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  dram_refresh_sched #(
    .CLKS_PER_INTERVAL(INTERVAL),
    .MAX_POSTPONE     (8),
    .STABLE_CYCLES    (STABLE),
    .NOP_CYCLES       (NOPS)
  ) u_dram_refresh_sched (
    .clk       (clk),
    .rstN      (rstN),
    .grant     (grant),
    .srEnterReq(srEnterReq),
    .srExitReq (srExitReq),
    .clkStable (clkStable),
    .refReq    (refReq),
    .refUrgent (refUrgent),
    .cke       (cke),
    .cmdCode   (cmdCode),
    .holdOff   (holdOff)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitUntil(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "refReq", refReq, 0);
    check("R1", "refUrgent", refUrgent, 0);
    check("R1", "cke", cke, 1);
    check("R1", "cmdCode", cmdCode, 0);
    check("R1", "holdOff", holdOff, 0);
    rstN = 1'b1;
  endtask

  task automatic testInterval();
    waitUntil(10);
    check("R2", "refReq before first interval", refReq, 0);
    waitUntil(20);
    check("R2", "refReq after first interval", refReq, 1);
    check("R2", "refUrgent with one owed", refUrgent, 0);
  endtask

  task automatic testGrant();
    grant = 1'b1; #1;
    check("R3", "cmdCode on grant", cmdCode, 1);
    @(negedge clk);
    grant = 1'b0;
    check("R3", "refReq after grant", refReq, 0);
    grant = 1'b1; #1;
    check("R3", "cmdCode on grant without request", cmdCode, 0);
    @(negedge clk);
    grant = 1'b0;
    check("R3", "refReq after ignored grant", refReq, 0);
  endtask

  task automatic testSaturate();
    waitUntil(INTERVAL * 8 + 4);
    check("R4", "refUrgent with seven owed", refUrgent, 0);
    check("R2", "refReq with seven owed", refReq, 1);
    waitUntil(INTERVAL * 9 + 4);
    check("R4", "refUrgent with eight owed", refUrgent, 1);
    waitUntil(INTERVAL * 12 + 1);
    check("R5", "refUrgent after extra intervals", refUrgent, 1);
    for (int i = 0; i < 8; i++) begin
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      if (i == 0) check("R4", "refUrgent after one grant", refUrgent, 0);
      if (i == 6) check("R5", "refReq after seven grants", refReq, 1);
    end
    check("R5", "refReq after eight grants", refReq, 0);
  endtask

  task automatic testEnter();
    int seen;
    waitUntil(INTERVAL * 14 + 2);
    check("R2", "refReq with two owed", refReq, 1);
    srEnterReq = 1'b1;
    @(negedge clk);
    srEnterReq = 1'b0;
    check("R6", "cke during drain", cke, 1);
    check("R6", "refReq during drain", refReq, 1);
    grant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    grant = 1'b0;
    check("R6", "refReq after drain", refReq, 0);
    seen = 0;
    for (int i = 0; i < 4 && seen == 0; i++) begin
      @(negedge clk);
      if (!cke) seen = 1;
    end
    check("R6", "cke fell after drain", seen, 1);
    check("R6", "cmdCode at entry", cmdCode, 1);
    @(negedge clk);
    check("R6", "cke after entry", cke, 0);
    check("R6", "cmdCode after entry", cmdCode, 0);
  endtask

  task automatic testSelf();
    int bad = 0;
    for (int i = 0; i < 5 * INTERVAL; i++) begin
      grant = 1'b1;
      srEnterReq = i[0];
      #1;
      if (cke || cmdCode != 2'd0 || refReq || !holdOff) bad++;
      @(negedge clk);
    end
    grant = 1'b0;
    srEnterReq = 1'b0;
    check("R7", "cycles with activity in self refresh", bad, 0);
  endtask

  task automatic testExit();
    clkStable = 1'b0;
    srExitReq = 1'b1;
    @(negedge clk);
    srExitReq = 1'b0;
    repeat (10) @(negedge clk);
    check("R8", "cke while clock unstable", cke, 0);
    clkStable = 1'b1;
    repeat (2) @(negedge clk);
    clkStable = 1'b0;
    @(negedge clk);
    check("R8", "cke after broken stable run", cke, 0);
    clkStable = 1'b1;
    repeat (STABLE - 1) @(negedge clk);
    check("R8", "cke one cycle before stable run ends", cke, 0);
    @(negedge clk);
    check("R8", "cke after stable run", cke, 1);
  endtask

  task automatic testHold();
    int n = 0;
    int bad = 0;
    grant = 1'b1;
    while (holdOff && n < 4 * NOPS) begin
      #1;
      if (cmdCode != 2'd0 || refReq) bad++;
      n++;
      @(negedge clk);
    end
    grant = 1'b0;
    check("R9", "holdOff length", n, NOPS);
    check("R9", "non-NOP cycles during hold", bad, 0);
  endtask

  task automatic testRestart();
    check("R10", "refReq when hold ends", refReq, 0);
    repeat (INTERVAL - 1) @(negedge clk);
    check("R10", "refReq one cycle before interval", refReq, 0);
    @(negedge clk);
    check("R10", "refReq after one interval", refReq, 1);
    check("R10", "refUrgent after one interval", refUrgent, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testInterval();
    testGrant();
    testSaturate();
    testEnter();
    testSelf();
    testExit();
    testHold();
    testRestart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule